// File: doc/BRIEF.md
# DRAM Mode Register Decoder with Latency Windows

This block sits on the device side of a graphics DRAM command path. It watches the registered command and address buses for load-mode commands. When all banks are idle, it decodes the address bits of such a command into CAS latency, write latency, burst length, test mode and a DLL reset request. The new values take effect after a fixed settle time. Commands that carry a reserved code are rejected. A rejected command leaves every setting as it was and raises a one-cycle flag. A second target stores the raw address word of an extended load.

The stored latencies and burst length drive two data-phase strobes. The read strobe opens CL clocks after a READ is registered. The write strobe opens WL clocks after a WRITE. Each strobe stays open for half the burst length in clocks, because two beats move per clock. A DLL reset request is a bit that clears itself after a lock interval. The same request holds a power-down guard for a fixed number of clocks.

Top module: `dram_mode_timer`

## Requirements
- R1: A load command is cs_n, ras_n, cas_n and we_n all sampled low. With ba = 00 it targets the mode settings. With ba[0] = 1 the 12-bit address word is stored in ext_mode. With ba = 10 the command is rejected, illegal_mode pulses, and nothing changes.
- R2: Burst length comes from addr[1:0]. Code 10 selects 4 beats (burst_len8 = 0) and 11 selects 8 beats (burst_len8 = 1). Codes 00 and 01 are reserved.
- R3: Write latency comes from addr[11:9]. Codes 001 to 111 give 1 to 7 clocks. Code 000 is reserved.
- R4: CAS latency comes from the 4-bit code {addr[2], addr[6:4]}. The legal codes are 0111 = 7, 0000 = 8, 0001 = 9, 0010 = 10, 0011 = 11 and 1000 = 12. Every other code is reserved.
- R5: A mode load is rejected as a whole when any field is reserved, or when addr[3] = 1 (only sequential ordering, addr[3] = 0, is supported). A rejected load leaves all settings unchanged. illegal_mode is then high for exactly the one cycle after the sampling edge.
- R6: A load sampled while banks_idle = 0 is ignored and raises no illegal_mode.
- R7: An accepted load sampled at edge n becomes visible after edge n+TMRD. Any load sampled while a previous one is still waiting to take effect is ignored.
- R8: A mode load with addr[8] = 1 raises dll_reset at the same edge its settings take effect. dll_reset stays high for DLL_LOCK cycles and then clears itself.
- R9: A mode load with addr[8] = 1 sampled at edge n holds pd_block high from edge n until edge n+PD_GUARD.
- R10: addr[7] of an accepted mode load is stored as test_mode.
- R11: A READ is cs_n = 0, ras_n = 1, cas_n = 0, we_n = 1. A READ sampled at edge n makes rd_valid high from edge n+CL for BL/2 cycles.
- R12: A WRITE is cs_n = 0, ras_n = 1, cas_n = 0, we_n = 0. A WRITE sampled at edge n makes wr_window high from edge n+WL for BL/2 cycles.
- R13: Commands spaced BL/2 clocks apart produce one contiguous window. The read and write windows are independent and may be high in the same cycle.
- R14: After reset the block shows CL 7, WL 1, 4-beat bursts, test_mode 0, ext_mode 0, and all strobes and flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | Registered chip select, active low |
| ras_n | input | 1 | Registered row strobe |
| cas_n | input | 1 | Registered column strobe |
| we_n | input | 1 | Registered write enable |
| ba | input | 2 | Registered bank address, selects the load target |
| addr | input | 12 | Registered address / op-code bus |
| banks_idle | input | 1 | High when every bank is precharged |
| cas_lat | output | 4 | Current CAS latency in clocks |
| wr_lat | output | 3 | Current write latency in clocks |
| burst_len8 | output | 1 | 1 for 8-beat bursts, 0 for 4-beat bursts |
| test_mode | output | 1 | Stored test-mode bit |
| dll_reset | output | 1 | Self-clearing DLL reset request |
| ext_mode | output | 12 | Raw word of the last extended load |
| illegal_mode | output | 1 | One-cycle pulse on a rejected load |
| pd_block | output | 1 | Power-down entry forbidden |
| rd_valid | output | 1 | Read data window |
| wr_window | output | 1 | Write data window |

## Verification
The read window and the write window can be high in the same cycle. The bench sets this up by issuing a WRITE a few clocks after a READ, with the spacing chosen so that the write latency lands the write window on the first clocks of the read window. Both strobes are then compared every cycle against windows computed from the logged command edges. A second same-cycle case has the DLL reset taking effect while the power-down guard is still open. Both outputs are checked at the edges where each one starts and ends.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_READ  = 2'd2,
    CMD_WRITE = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [3:0] cl;
    logic [2:0] wl;
    logic       bl8;
    logic       tm;
  } mode_t;

  localparam logic [3:0] CL_RESET = 4'd7;
  localparam logic [2:0] WL_RESET = 3'd1;

endpackage

// File: rtl/dmt_cmd_dec.sv
module dmt_cmd_dec
  import dmt_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_LOAD;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        default: cmd = CMD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/dmt_field_dec.sv
module dmt_field_dec
  import dmt_pkg::*;
(
  input  logic [11:0] op,
  output mode_t       fields,
  output logic        dll_req,
  output logic        legal
);

  logic bl_ok, cl_ok, wl_ok, order_ok;

  always_comb begin
    fields = '0;
    bl_ok  = 1'b1;
    cl_ok  = 1'b1;

    // burst length code
    case (op[1:0])
      2'b10:   fields.bl8 = 1'b0;
      2'b11:   fields.bl8 = 1'b1;
      default: bl_ok      = 1'b0;
    endcase

    // CAS latency: high code bit sits apart from the other three
    case ({op[2], op[6:4]})
      4'b0111: fields.cl = 4'd7;
      4'b0000: fields.cl = 4'd8;
      4'b0001: fields.cl = 4'd9;
      4'b0010: fields.cl = 4'd10;
      4'b0011: fields.cl = 4'd11;
      4'b1000: fields.cl = 4'd12;
      default: cl_ok     = 1'b0;
    endcase

    fields.wl = op[11:9];
    wl_ok     = |op[11:9];
    fields.tm = op[7];
    order_ok  = ~op[3];
    dll_req   = op[8];
    legal     = bl_ok & cl_ok & wl_ok & order_ok;
  end

endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
  import dmt_pkg::*;
#(
  parameter int TMRD     = 4,
  parameter int DLL_LOCK = 2048,
  parameter int PD_GUARD = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        banks_idle,
  input  logic [1:0]  ba,
  input  logic [11:0] op,
  input  mode_t       dec_fields,
  input  logic        dec_dll,
  input  logic        dec_legal,
  output mode_t       mode,
  output logic [11:0] ext_word,
  output logic        bad_pulse,
  output logic        dll_active,
  output logic        pd_guard
);

  localparam int TW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam int DW = $clog2(DLL_LOCK + 1);
  localparam int PW = $clog2(PD_GUARD + 1);

  // pending slot
  logic          pend_q, pend_d;
  logic [TW-1:0] pcnt_q, pcnt_d;
  logic          pext_q, pext_d;
  logic          pdll_q, pdll_d;
  mode_t         pmode_q, pmode_d;
  logic [11:0]   praw_q, praw_d;
  logic          cap_en;

  // visible state
  mode_t         mode_q, mode_d;
  logic [11:0]   ext_q, ext_d;
  logic          mode_en, ext_en;
  logic          bad_q, bad_d;
  logic [DW-1:0] dcnt_q, dcnt_d;
  logic [PW-1:0] gcnt_q, gcnt_d;

  logic accept, take_mode, take_ext, commit;

  always_comb begin
    accept    = load & banks_idle & ~pend_q;
    take_mode = accept & (ba == 2'b00) & dec_legal;
    take_ext  = accept & ba[0];
    bad_d     = accept & ~(take_mode | take_ext);
    commit    = pend_q & (pcnt_q == '0);

    pend_d  = pend_q;
    pcnt_d  = pcnt_q;
    cap_en  = 1'b0;
    pext_d  = take_ext;
    pdll_d  = dec_dll & take_mode;
    pmode_d = dec_fields;
    praw_d  = op;
    mode_d  = pmode_q;
    ext_d   = praw_q;
    mode_en = 1'b0;
    ext_en  = 1'b0;

    if (pend_q) begin
      if (commit) begin
        pend_d  = 1'b0;
        mode_en = ~pext_q;
        ext_en  = pext_q;
      end else begin
        pcnt_d = pcnt_q - 1'b1;
      end
    end else if (take_mode | take_ext) begin
      pend_d = 1'b1;
      pcnt_d = TW'(TMRD - 1);
      cap_en = 1'b1;
    end

    if (commit & ~pext_q & pdll_q) dcnt_d = DW'(DLL_LOCK);
    else if (dcnt_q != '0)         dcnt_d = dcnt_q - 1'b1;
    else                           dcnt_d = dcnt_q;

    if (take_mode & dec_dll) gcnt_d = PW'(PD_GUARD);
    else if (gcnt_q != '0)   gcnt_d = gcnt_q - 1'b1;
    else                     gcnt_d = gcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pcnt_q <= '0;
    end else begin
      pend_q <= pend_d;
      pcnt_q <= pcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pext_q  <= 1'b0;
      pdll_q  <= 1'b0;
      pmode_q <= '0;
      praw_q  <= '0;
    end else if (cap_en) begin
      pext_q  <= pext_d;
      pdll_q  <= pdll_d;
      pmode_q <= pmode_d;
      praw_q  <= praw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{cl: CL_RESET, wl: WL_RESET, bl8: 1'b0, tm: 1'b0};
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= '0;
    else if (ext_en) ext_q <= ext_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q  <= 1'b0;
      dcnt_q <= '0;
      gcnt_q <= '0;
    end else begin
      bad_q  <= bad_d;
      dcnt_q <= dcnt_d;
      gcnt_q <= gcnt_d;
    end
  end

  assign mode       = mode_q;
  assign ext_word   = ext_q;
  assign bad_pulse  = bad_q;
  assign dll_active = (dcnt_q != '0);
  assign pd_guard   = (gcnt_q != '0);

endmodule

// File: rtl/dmt_window.sv
module dmt_window #(
  parameter int MAX_LAT  = 12,
  parameter int HALF_MAX = 4,
  parameter int LW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [LW-1:0] lat,
  input  logic          bl8,
  output logic          win
);

  localparam int DEPTH = MAX_LAT + HALF_MAX;
  localparam int IW    = $clog2(DEPTH);

  logic [DEPTH-1:0] hist_q, hist_d;
  logic [IW:0]      pos;
  logic [IW:0]      span;

  always_comb begin
    hist_d = {hist_q[DEPTH-2:0], fire};
    span   = bl8 ? (IW+1)'(HALF_MAX) : (IW+1)'(HALF_MAX / 2);
    win    = 1'b0;
    pos    = '0;
    for (int j = 0; j < HALF_MAX; j++) begin
      pos = (IW+1)'(lat) + (IW+1)'(j);
      if (((IW+1)'(j) < span) && (pos < (IW+1)'(DEPTH)))
        win = win | hist_q[pos[IW-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

endmodule

// File: rtl/dram_mode_timer.sv
module dram_mode_timer
  import dmt_pkg::*;
#(
  parameter int TMRD     = 4,
  parameter int DLL_LOCK = 2048,
  parameter int PD_GUARD = 10,
  parameter int CL_MAX   = 12,
  parameter int WL_MAX   = 7,
  parameter int HALF_MAX = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic [1:0]  ba,
  input  logic [11:0] addr,
  input  logic        banks_idle,
  output logic [3:0]  cas_lat,
  output logic [2:0]  wr_lat,
  output logic        burst_len8,
  output logic        test_mode,
  output logic        dll_reset,
  output logic [11:0] ext_mode,
  output logic        illegal_mode,
  output logic        pd_block,
  output logic        rd_valid,
  output logic        wr_window
);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  cmd_e       cmd;
  mode_t      dec_fields, mode;
  logic       dec_dll, dec_legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  dmt_cmd_dec u_cmd (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (cmd)
  );

  dmt_field_dec u_fld (
    .op     (addr),
    .fields (dec_fields),
    .dll_req(dec_dll),
    .legal  (dec_legal)
  );

  dmt_regs #(
    .TMRD    (TMRD),
    .DLL_LOCK(DLL_LOCK),
    .PD_GUARD(PD_GUARD)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (cmd == CMD_LOAD),
    .banks_idle(banks_idle),
    .ba        (ba),
    .op        (addr),
    .dec_fields(dec_fields),
    .dec_dll   (dec_dll),
    .dec_legal (dec_legal),
    .mode      (mode),
    .ext_word  (ext_mode),
    .bad_pulse (illegal_mode),
    .dll_active(dll_reset),
    .pd_guard  (pd_block)
  );

  dmt_window #(.MAX_LAT(CL_MAX), .HALF_MAX(HALF_MAX), .LW(4)) u_rdwin (
    .clk  (clk),
    .rst_n(rst_i),
    .fire (cmd == CMD_READ),
    .lat  (mode.cl),
    .bl8  (mode.bl8),
    .win  (rd_valid)
  );

  dmt_window #(.MAX_LAT(WL_MAX), .HALF_MAX(HALF_MAX), .LW(3)) u_wrwin (
    .clk  (clk),
    .rst_n(rst_i),
    .fire (cmd == CMD_WRITE),
    .lat  (mode.wl),
    .bl8  (mode.bl8),
    .win  (wr_window)
  );

  assign cas_lat    = mode.cl;
  assign wr_lat     = mode.wl;
  assign burst_len8 = mode.bl8;
  assign test_mode  = mode.tm;

endmodule

// File: rtl/dmt_chk.sv
module dmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        ras_n,
  input logic        cas_n,
  input logic        we_n,
  input logic        banks_idle,
  input logic [3:0]  cas_lat,
  input logic [2:0]  wr_lat,
  input logic        burst_len8,
  input logic        test_mode,
  input logic        dll_reset,
  input logic        illegal_mode,
  input logic        pd_block
);

  logic load_seen;
  assign load_seen = !cs_n && !ras_n && !cas_n && !we_n;

  p_cl_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat >= 4'd7) && (cas_lat <= 4'd12));

  p_wl_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lat != 3'd0);

  p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |-> $stable({cas_lat, wr_lat, burst_len8, test_mode}));

  p_busy_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_seen && !banks_idle) |=> !illegal_mode);

  p_guard_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_block) |=> pd_block);

  p_dll_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dll_reset) |=> dll_reset);

endmodule

bind dram_mode_timer dmt_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .banks_idle  (banks_idle),
  .cas_lat     (cas_lat),
  .wr_lat      (wr_lat),
  .burst_len8  (burst_len8),
  .test_mode   (test_mode),
  .dll_reset   (dll_reset),
  .illegal_mode(illegal_mode),
  .pd_block    (pd_block)
);

// File: tb/sim_dram_mode_timer.sv
module sim_dram_mode_timer;

  localparam int TMRD     = 4;
  localparam int DLL_LOCK = 30;
  localparam int PD_GUARD = 10;

  localparam logic [3:0] C_LOAD  = 4'b0000;
  localparam logic [3:0] C_READ  = 4'b0101;
  localparam logic [3:0] C_WRITE = 4'b0100;
  localparam logic [3:0] C_NOP   = 4'b0111;

  // {op[11:0], cl[3:0], wl[2:0], bl8, rejected}
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {12'h603, 4'd8,  3'd3, 1'b1, 1'b0},
    {12'hE06, 4'd12, 3'd7, 1'b0, 1'b0},
    {12'h413, 4'd9,  3'd2, 1'b1, 1'b0},
    {12'hA21, 4'd9,  3'd2, 1'b1, 1'b1},
    {12'h032, 4'd9,  3'd2, 1'b1, 1'b1},
    {12'h842, 4'd9,  3'd2, 1'b1, 1'b1},
    {12'h816, 4'd9,  3'd2, 1'b1, 1'b1},
    {12'h82A, 4'd9,  3'd2, 1'b1, 1'b1},
    {12'h872, 4'd7,  3'd4, 1'b0, 1'b0},
    {12'hC23, 4'd10, 3'd6, 1'b1, 1'b0},
    {12'hA32, 4'd11, 3'd5, 1'b0, 1'b0}
  };

  logic        clk, rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        banks_idle;
  logic [3:0]  cas_lat;
  logic [2:0]  wr_lat;
  logic        burst_len8, test_mode, dll_reset, illegal_mode, pd_block;
  logic        rd_valid, wr_window;
  logic [11:0] ext_mode;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  dram_mode_timer #(.TMRD(TMRD), .DLL_LOCK(DLL_LOCK), .PD_GUARD(PD_GUARD)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .banks_idle(banks_idle),
    .cas_lat(cas_lat), .wr_lat(wr_lat), .burst_len8(burst_len8),
    .test_mode(test_mode), .dll_reset(dll_reset), .ext_mode(ext_mode),
    .illegal_mode(illegal_mode), .pd_block(pd_block),
    .rd_valid(rd_valid), .wr_window(wr_window)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba   = b;
    addr = a;
  endtask

  // issue one command; returns just after the edge that sampled it
  task automatic cmd1(input logic [3:0] c, input logic [1:0] b, input logic [11:0] a);
    drive(c, b, a);
    drive(C_NOP, 2'b00, 12'h000);
  endtask

  task automatic win_run(input int cl, input int wl, input int half,
                         input int rd0, input int rd1, input int wr0, input int wr1,
                         input string tag);
    int rdl[2];
    int wrl[2];
    rdl = '{-1000, -1000};
    wrl = '{-1000, -1000};
    for (int i = 0; i < 30; i++) begin
      logic er, ew;
      @(negedge clk);
      er = 1'b0;
      ew = 1'b0;
      for (int k = 0; k < 2; k++) begin
        if ((cyc - rdl[k] >= cl) && (cyc - rdl[k] < cl + half)) er = 1'b1;
        if ((cyc - wrl[k] >= wl) && (cyc - wrl[k] < wl + half)) ew = 1'b1;
      end
      check({"R11 R13 rd_valid ", tag}, 32'(rd_valid), 32'(er));
      check({"R12 R13 wr_window ", tag}, 32'(wr_window), 32'(ew));
      {cs_n, ras_n, cas_n, we_n} = C_NOP;
      if (i == rd0) begin {cs_n, ras_n, cas_n, we_n} = C_READ;  rdl[0] = cyc + 1; end
      if (i == rd1) begin {cs_n, ras_n, cas_n, we_n} = C_READ;  rdl[1] = cyc + 1; end
      if (i == wr0) begin {cs_n, ras_n, cas_n, we_n} = C_WRITE; wrl[0] = cyc + 1; end
      if (i == wr1) begin {cs_n, ras_n, cas_n, we_n} = C_WRITE; wrl[1] = cyc + 1; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = C_NOP;
    ba = 2'b00;
    addr = 12'h000;
    banks_idle = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14 reset state
    check("R14 cas_lat", 32'(cas_lat), 32'd7);
    check("R14 wr_lat", 32'(wr_lat), 32'd1);
    check("R14 burst_len8", 32'(burst_len8), 32'd0);
    check("R14 test_mode", 32'(test_mode), 32'd0);
    check("R14 dll_reset", 32'(dll_reset), 32'd0);
    check("R14 ext_mode", 32'(ext_mode), 32'd0);
    check("R14 illegal_mode", 32'(illegal_mode), 32'd0);
    check("R14 pd_block", 32'(pd_block), 32'd0);
    check("R14 rd_valid", 32'(rd_valid), 32'd0);
    check("R14 wr_window", 32'(wr_window), 32'd0);

    // table of mode loads: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      cmd1(C_LOAD, 2'b00, v[20:9]);
      check("R5 illegal_mode pulse", 32'(illegal_mode), 32'(v[0]));
      repeat (TMRD) @(negedge clk);
      check("R4 cas_lat", 32'(cas_lat), 32'(v[8:5]));
      check("R3 wr_lat", 32'(wr_lat), 32'(v[4:2]));
      check("R2 burst_len8", 32'(burst_len8), 32'(v[1]));
      if (v[0]) begin
        @(negedge clk);
        check("R5 illegal_mode one cycle", 32'(illegal_mode), 32'd0);
      end
    end

    // R6 busy banks: load ignored, no flag
    banks_idle = 1'b0;
    cmd1(C_LOAD, 2'b00, 12'h603);
    check("R6 no illegal_mode", 32'(illegal_mode), 32'd0);
    repeat (TMRD + 2) @(negedge clk);
    check("R6 cas_lat kept", 32'(cas_lat), 32'd11);
    banks_idle = 1'b1;

    // R7 settle time
    cmd1(C_LOAD, 2'b00, 12'h413);
    repeat (TMRD - 1) @(negedge clk);
    check("R7 cas_lat before settle", 32'(cas_lat), 32'd11);
    @(negedge clk);
    check("R7 cas_lat after settle", 32'(cas_lat), 32'd9);
    // R7 second load while pending is dropped
    drive(C_LOAD, 2'b00, 12'h603);
    drive(C_LOAD, 2'b00, 12'hE06);
    drive(C_NOP, 2'b00, 12'h000);
    check("R7 no illegal_mode", 32'(illegal_mode), 32'd0);
    repeat (TMRD + 3) @(negedge clk);
    check("R7 cas_lat first wins", 32'(cas_lat), 32'd8);
    check("R7 wr_lat first wins", 32'(wr_lat), 32'd3);

    // R1 extended target
    cmd1(C_LOAD, 2'b01, 12'h5A5);
    repeat (TMRD) @(negedge clk);
    check("R1 ext_mode ba01", 32'(ext_mode), 32'h5A5);
    check("R1 cas_lat untouched", 32'(cas_lat), 32'd8);
    cmd1(C_LOAD, 2'b11, 12'h3C3);
    repeat (TMRD) @(negedge clk);
    check("R1 ext_mode ba11", 32'(ext_mode), 32'h3C3);
    cmd1(C_LOAD, 2'b10, 12'h0FF);
    check("R1 ba10 rejected", 32'(illegal_mode), 32'd1);
    repeat (TMRD) @(negedge clk);
    check("R1 ext_mode kept", 32'(ext_mode), 32'h3C3);
    check("R1 wr_lat kept", 32'(wr_lat), 32'd3);

    // R10 test mode bit
    cmd1(C_LOAD, 2'b00, 12'h683);
    repeat (TMRD) @(negedge clk);
    check("R10 test_mode set", 32'(test_mode), 32'd1);
    cmd1(C_LOAD, 2'b00, 12'h603);
    repeat (TMRD) @(negedge clk);
    check("R10 test_mode clear", 32'(test_mode), 32'd0);

    // R8 R9 DLL reset and power-down guard
    cmd1(C_LOAD, 2'b00, 12'h703);
    check("R9 pd_block starts", 32'(pd_block), 32'd1);
    repeat (TMRD - 1) @(negedge clk);
    check("R8 dll_reset before settle", 32'(dll_reset), 32'd0);
    @(negedge clk);
    check("R8 dll_reset raised", 32'(dll_reset), 32'd1);
    check("R9 pd_block during dll", 32'(pd_block), 32'd1);
    repeat (PD_GUARD - 1 - TMRD) @(negedge clk);
    check("R9 pd_block last cycle", 32'(pd_block), 32'd1);
    @(negedge clk);
    check("R9 pd_block released", 32'(pd_block), 32'd0);
    repeat (TMRD + DLL_LOCK - 1 - PD_GUARD) @(negedge clk);
    check("R8 dll_reset last cycle", 32'(dll_reset), 32'd1);
    @(negedge clk);
    check("R8 dll_reset self-cleared", 32'(dll_reset), 32'd0);
    check("R8 cas_lat applied", 32'(cas_lat), 32'd8);

    // windows: CL8 WL3 BL8, write window overlaps read window
    win_run(8, 3, 4, 2, 6, 7, -1, "cl8 wl3 bl8");

    // CL12 WL7 BL4
    cmd1(C_LOAD, 2'b00, 12'hE06);
    repeat (TMRD) @(negedge clk);
    win_run(12, 7, 2, 1, 3, 6, -1, "cl12 wl7 bl4");

    // CL7 WL1 BL4, back-to-back writes
    cmd1(C_LOAD, 2'b00, 12'h272);
    repeat (TMRD) @(negedge clk);
    check("R4 cas_lat 7", 32'(cas_lat), 32'd7);
    check("R3 wr_lat 1", 32'(wr_lat), 32'd1);
    win_run(7, 1, 2, 0, 2, 3, 5, "cl7 wl1 bl4");

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule